// File: doc/BRIEF.md
# Receive Line Idle Detector with Once-per-Idle Interrupt

This block sits next to a serial receiver and watches the receive line on an oversampling tick. It keeps a live flag that says whether the line is idle. The line counts as idle after one full frame time of unbroken ones, where a frame is 10 or 11 bit times as chosen by a word-size select input. The flag drops as soon as a start bit is confirmed by a low level held to the middle of the bit. A small frame tracker follows each character from its confirmed start bit to the middle of its stop bit and emits a one-cycle character-received pulse there. It does not recover data bits and does not check framing.

An interrupt enable is held in the block. Software sets and clears it through a write strobe, and either reset clears it. When the line is idle, the enable is set and a character has arrived since the last interrupt, the block raises a registered request. The request stays up until the interrupt controller acknowledges it, even if the line leaves the idle state first. Because an arm flag is set only by a received character and is consumed when the request fires, one idle period yields at most one interrupt, however long it lasts. No interrupt comes before the first character after reset.

Top module: `idle_irq_ctrl`

## Requirements
- R1: After `rstN` is low, `lineIdle`, `idleIrq`, `charDone` and `irqEnable` are all 0.
- R2: While no character is being tracked, `lineIdle` rises on the sample tick that completes F*OVS consecutive high samples, with F = 10 when `longWord` is 0 and F = 11 when it is 1. On the tick before that it is still 0. After a character, this count starts with the first tick after the middle of its stop bit.
- R3: A start bit is confirmed on the (OVS/2)-th consecutive low sample, and `lineIdle` is 0 right after that tick. A low pulse shorter than OVS/2 ticks neither clears `lineIdle` nor produces `charDone`.
- R4: `charDone` is a one-cycle pulse following the tick numbered OVS/2 + (F-1)*OVS - 1, counting from 0 at the first low tick of the start bit.
- R5: `idleIrq` rises one clock after `lineIdle` is 1 while the enable is set and a character has been received since the last interrupt.
- R6: Once raised, `idleIrq` stays 1 until `irqAck` is high at a clock edge, even if a new character starts on the line.
- R7: Only one interrupt is raised per idle period. After acknowledgment, no further interrupt comes, however long the idle lasts, until another character is received. A character received while a request is pending arms a fresh interrupt for the next idle period.
- R8: No idle interrupt is raised after reset until a first character has been received.
- R9: A high `enWrite` loads `enData` into the enable, visible on `irqEnable`. A pulse on `softRst` clears the enable. Clearing the enable by either means drops a pending `idleIrq` on the same edge.
- R10: If the enable is set while the line is already idle and a character is armed, `idleIrq` rises one clock after the enable becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| softRst | input | 1 | Soft reset pulse; clears the interrupt enable |
| sampleTick | input | 1 | Oversampling strobe, OVS per bit time |
| rxLine | input | 1 | Receive line, synchronous to clk, high when idle |
| longWord | input | 1 | Frame length select: 0 for 10 bits, 1 for 11 bits |
| enWrite | input | 1 | Write strobe for the interrupt enable |
| enData | input | 1 | Value written into the interrupt enable |
| irqAck | input | 1 | Interrupt acknowledge from the interrupt controller |
| lineIdle | output | 1 | Live idle status of the receive line |
| idleIrq | output | 1 | Idle interrupt request, held until acknowledged |
| charDone | output | 1 | One-cycle pulse when a character frame completes |
| irqEnable | output | 1 | Current value of the interrupt enable |

## Verification
The hardest case to reach is a second idle period that starts while the first request is still pending. A character has to arrive before the acknowledge and the line has to go idle again, so that the acknowledge and the re-armed request meet. The directed stimulus builds this by sending a full character without acknowledging and then holding the line high for a full frame time. Two consecutive cycles are then checked: low just after the acknowledge, high one edge later. Random passes vary the frame length, the data bits and the idle gap around the exact threshold tick, and the expected idle and request levels are computed from the gap length.

// File: rtl/idle_irq_pkg.sv
package idle_irq_pkg;

  typedef enum logic [1:0] {
    RX_HUNT  = 2'd0,
    RX_START = 2'd1,
    RX_FRAME = 2'd2
  } rxState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic phaseClr;
    logic phaseInc;
    logic idleRun;
    logic idleClr;
  } dpCmd_t;

  // conditions reported by the datapath
  typedef struct packed {
    logic halfLow;
    logic frameLast;
    logic idleHit;
  } dpStat_t;

endpackage

// File: rtl/idle_irq_dp.sv
module idle_irq_dp
  import idle_irq_pkg::*;
#(
  parameter int OVS = 8  // ticks per bit, even, at least 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sampleTick,
  input  logic    rxLine,
  input  logic    longWord,
  input  dpCmd_t  cmd,
  output dpStat_t stat,
  output logic    lineIdle
);

  localparam int HALF    = OVS / 2;
  localparam int MAXBITS = 11;
  localparam int CW      = $clog2(MAXBITS * OVS + 1);

  localparam logic [CW-1:0] HALF_M2    = CW'(HALF - 2);
  localparam logic [CW-1:0] FRAME_SHRT = CW'((MAXBITS - 2) * OVS);
  localparam logic [CW-1:0] FRAME_LONG = CW'((MAXBITS - 1) * OVS);
  localparam logic [CW-1:0] IDLE_SHRT  = CW'((MAXBITS - 1) * OVS);
  localparam logic [CW-1:0] IDLE_LONG  = CW'(MAXBITS * OVS);

  logic [CW-1:0] phaseCnt;
  logic [CW-1:0] idleCnt;
  logic [CW-1:0] frameTicks;
  logic [CW-1:0] idleTicks;
  logic          idleHit;

  assign frameTicks = longWord ? FRAME_LONG : FRAME_SHRT;
  assign idleTicks  = longWord ? IDLE_LONG  : IDLE_SHRT;

  // phase counter shared by start-bit check and frame timing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseCnt <= '0;
    end else if (cmd.phaseClr) begin
      phaseCnt <= '0;
    end else if (cmd.phaseInc) begin
      phaseCnt <= phaseCnt + 1'b1;
    end
  end

  // run length of high samples while hunting
  always_ff @(posedge clk) begin
    if (!rstN) begin
      idleCnt <= '0;
    end else if (sampleTick) begin
      if (!cmd.idleRun || !rxLine) begin
        idleCnt <= '0;
      end else if (idleCnt < idleTicks - 1'b1) begin
        idleCnt <= idleCnt + 1'b1;
      end
    end
  end

  assign idleHit = sampleTick && cmd.idleRun && rxLine &&
                   (idleCnt >= idleTicks - 1'b1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineIdle <= 1'b0;
    end else if (cmd.idleClr) begin
      lineIdle <= 1'b0;
    end else if (idleHit) begin
      lineIdle <= 1'b1;
    end
  end

  assign stat.halfLow   = (phaseCnt == HALF_M2);
  assign stat.frameLast = (phaseCnt >= frameTicks - 1'b1);
  assign stat.idleHit   = idleHit;

endmodule

// File: rtl/idle_irq_ctl.sv
module idle_irq_ctl
  import idle_irq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    softRst,
  input  logic    sampleTick,
  input  logic    rxLine,
  input  logic    enWrite,
  input  logic    enData,
  input  logic    irqAck,
  input  logic    lineIdle,
  input  dpStat_t stat,
  output dpCmd_t  cmd,
  output logic    charDone,
  output logic    idleIrq,
  output logic    irqEnable
);

  rxState_e state, stateNext;
  logic     doneNext;
  logic     armed;
  logic     fire;
  logic     killIrq;

  // frame tracker
  always_comb begin
    stateNext    = state;
    doneNext     = 1'b0;
    cmd          = '0;
    cmd.idleRun  = (state == RX_HUNT);
    unique case (state)
      RX_HUNT: begin
        if (sampleTick && !rxLine) begin
          stateNext    = RX_START;
          cmd.phaseClr = 1'b1;
        end
      end
      RX_START: begin
        if (sampleTick) begin
          if (rxLine) begin
            stateNext = RX_HUNT;
          end else if (stat.halfLow) begin
            stateNext    = RX_FRAME;
            cmd.phaseClr = 1'b1;
            cmd.idleClr  = 1'b1;
          end else begin
            cmd.phaseInc = 1'b1;
          end
        end
      end
      RX_FRAME: begin
        if (sampleTick) begin
          if (stat.frameLast) begin
            stateNext = RX_HUNT;
            doneNext  = 1'b1;
          end else begin
            cmd.phaseInc = 1'b1;
          end
        end
      end
      default: stateNext = RX_HUNT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= RX_HUNT;
      charDone <= 1'b0;
    end else begin
      state    <= stateNext;
      charDone <= doneNext;
    end
  end

  // enable register
  always_ff @(posedge clk) begin
    if (!rstN || softRst) begin
      irqEnable <= 1'b0;
    end else if (enWrite) begin
      irqEnable <= enData;
    end
  end

  assign fire    = lineIdle && irqEnable && armed && !idleIrq;
  assign killIrq = softRst || (enWrite && !enData) || !irqEnable;

  // arm flag: a character arms, a fired request consumes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed <= 1'b0;
    end else if (charDone) begin
      armed <= 1'b1;
    end else if (fire) begin
      armed <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idleIrq <= 1'b0;
    end else if (killIrq) begin
      idleIrq <= 1'b0;
    end else if (fire) begin
      idleIrq <= 1'b1;
    end else if (irqAck) begin
      idleIrq <= 1'b0;
    end
  end

endmodule

// File: rtl/idle_irq_ctrl.sv
module idle_irq_ctrl
  import idle_irq_pkg::*;
#(
  parameter int OVS = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic softRst,
  input  logic sampleTick,
  input  logic rxLine,
  input  logic longWord,
  input  logic enWrite,
  input  logic enData,
  input  logic irqAck,
  output logic lineIdle,
  output logic idleIrq,
  output logic charDone,
  output logic irqEnable
);

  dpCmd_t  cmd;
  dpStat_t stat;

  idle_irq_dp #(.OVS(OVS)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .sampleTick (sampleTick),
    .rxLine     (rxLine),
    .longWord   (longWord),
    .cmd        (cmd),
    .stat       (stat),
    .lineIdle   (lineIdle)
  );

  idle_irq_ctl i_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .softRst    (softRst),
    .sampleTick (sampleTick),
    .rxLine     (rxLine),
    .enWrite    (enWrite),
    .enData     (enData),
    .irqAck     (irqAck),
    .lineIdle   (lineIdle),
    .stat       (stat),
    .cmd        (cmd),
    .charDone   (charDone),
    .idleIrq    (idleIrq),
    .irqEnable  (irqEnable)
  );

endmodule

// File: rtl/idle_irq_chk.sv
module idle_irq_chk (
  input logic clk,
  input logic rstN,
  input logic softRst,
  input logic enWrite,
  input logic irqAck,
  input logic rxLine,
  input logic lineIdle,
  input logic idleIrq,
  input logic charDone,
  input logic irqEnable
);

  logic armSeen;
  logic irqPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armSeen <= 1'b0;
      irqPrev <= 1'b0;
    end else begin
      irqPrev <= idleIrq;
      if (charDone) begin
        armSeen <= 1'b1;
      end else if (idleIrq && !irqPrev) begin
        armSeen <= 1'b0;
      end
    end
  end

  assert_idle_rise_on_high_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lineIdle) |-> $past(rxLine));

  assert_idle_fall_on_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lineIdle) |-> !$past(rxLine));

  assert_char_pulse_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    charDone |=> !charDone);

  assert_irq_needs_idle_en_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(idleIrq) |-> ($past(lineIdle) && $past(irqEnable)));

  assert_irq_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    (idleIrq && !irqAck && irqEnable && !softRst && !enWrite) |=> idleIrq);

  // covers R8 as well: no rise without a character since the last one
  assert_irq_needs_char_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(idleIrq) |-> $past(armSeen));

  assert_enable_clear_source_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqEnable) |-> ($past(softRst) || $past(enWrite)));

endmodule

bind idle_irq_ctrl idle_irq_chk i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .softRst   (softRst),
  .enWrite   (enWrite),
  .irqAck    (irqAck),
  .rxLine    (rxLine),
  .lineIdle  (lineIdle),
  .idleIrq   (idleIrq),
  .charDone  (charDone),
  .irqEnable (irqEnable)
);

// File: tb/test_idle_irq_ctrl.sv
`timescale 1ns/1ps
module test_idle_irq_ctrl;

  localparam int OVS  = 8;
  localparam int HALF = OVS / 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic softRst = 1'b0;
  logic sampleTick = 1'b0;
  logic rxLine = 1'b1;
  logic longWord = 1'b0;
  logic enWrite = 1'b0;
  logic enData = 1'b0;
  logic irqAck = 1'b0;
  logic lineIdle, idleIrq, charDone, irqEnable;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  idle_irq_ctrl #(.OVS(OVS)) i_idle_irq_ctrl (
    .clk(clk), .rstN(rstN), .softRst(softRst), .sampleTick(sampleTick),
    .rxLine(rxLine), .longWord(longWord), .enWrite(enWrite), .enData(enData),
    .irqAck(irqAck), .lineIdle(lineIdle), .idleIrq(idleIrq),
    .charDone(charDone), .irqEnable(irqEnable)
  );

  function automatic int frameBits(input logic lw);
    return lw ? 11 : 10;
  endfunction

  // high ticks after a frame's last tick until lineIdle rises (R2)
  function automatic int gapToIdle(input logic lw);
    return HALF + (frameBits(lw) - 1) * OVS;
  endfunction

  // tick index of the charDone pulse within a frame (R4)
  function automatic int doneTick(input logic lw);
    return HALF + (frameBits(lw) - 1) * OVS - 1;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input logic b);
    @(negedge clk);
    rxLine = b;
    sampleTick = 1'b1;
    @(negedge clk);
    sampleTick = 1'b0;
  endtask

  task automatic highs(input int n);
    for (int i = 0; i < n; i++) tick(1'b1);
  endtask

  task automatic sendChar(input logic [8:0] d, input logic lw,
                          output int doneAt, output int idleAtConfirm);
    int fb;
    logic b;
    fb = frameBits(lw);
    longWord = lw;
    doneAt = -1;
    idleAtConfirm = -1;
    for (int i = 0; i < fb * OVS; i++) begin
      int bitIdx;
      bitIdx = i / OVS;
      if (bitIdx == 0) b = 1'b0;
      else if (bitIdx <= fb - 2) b = d[bitIdx-1];
      else b = 1'b1;
      tick(b);
      if (charDone) doneAt = i;
      if (i == HALF - 1) idleAtConfirm = int'(lineIdle);
    end
  endtask

  task automatic writeEn(input logic v);
    @(negedge clk);
    enWrite = 1'b1;
    enData = v;
    @(negedge clk);
    enWrite = 1'b0;
  endtask

  task automatic pulseAck();
    @(negedge clk);
    irqAck = 1'b1;
    @(negedge clk);
    irqAck = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int doneAt, idleC, g;
    logic lw;
    logic [8:0] d;
    bit armedM;
    void'($urandom(32'd4242));

    doReset();
    check("R1 lineIdle", int'(lineIdle), 0);
    check("R1 idleIrq", int'(idleIrq), 0);
    check("R1 irqEnable", int'(irqEnable), 0);
    check("R1 charDone", int'(charDone), 0);

    writeEn(1'b1);
    check("R9 enable write", int'(irqEnable), 1);

    // power-up idle: 10*OVS high ticks
    highs(10 * OVS - 1);
    check("R2 not yet idle", int'(lineIdle), 0);
    tick(1'b1);
    check("R2 idle at threshold", int'(lineIdle), 1);
    @(negedge clk);
    check("R8 no irq before first char", int'(idleIrq), 0);

    // glitch shorter than half a bit
    for (int i = 0; i < HALF - 1; i++) tick(1'b0);
    tick(1'b1);
    check("R3 glitch keeps idle", int'(lineIdle), 1);
    highs(2 * OVS);
    check("R3 glitch no char", int'(charDone), 0);
    check("R8 still no irq", int'(idleIrq), 0);

    // first character
    sendChar(9'h0A5, 1'b0, doneAt, idleC);
    check("R3 start confirm clears idle", idleC, 0);
    check("R4 charDone tick", doneAt, doneTick(1'b0));
    highs(gapToIdle(1'b0) - 1);
    check("R2 gap below threshold", int'(lineIdle), 0);
    check("R5 no irq before idle", int'(idleIrq), 0);
    tick(1'b1);
    check("R2 gap at threshold", int'(lineIdle), 1);
    @(negedge clk);
    check("R5 irq fires", int'(idleIrq), 1);

    // hold request across a new character
    sendChar(9'h03C, 1'b0, doneAt, idleC);
    check("R6 held across char", int'(idleIrq), 1);
    highs(gapToIdle(1'b0));
    @(negedge clk);
    check("R6 still pending", int'(idleIrq), 1);
    pulseAck();
    check("R6 ack clears", int'(idleIrq), 0);
    @(negedge clk);
    check("R7 rearmed second period", int'(idleIrq), 1);
    pulseAck();
    check("R6 ack clears again", int'(idleIrq), 0);
    highs(3 * gapToIdle(1'b0));
    check("R7 no refire in long idle", int'(idleIrq), 0);
    check("R7 line still idle", int'(lineIdle), 1);

    // clearing the enable drops a pending request
    sendChar(9'h155, 1'b0, doneAt, idleC);
    highs(gapToIdle(1'b0));
    @(negedge clk);
    check("R5 irq for R9 case", int'(idleIrq), 1);
    writeEn(1'b0);
    check("R9 enable clear drops irq", int'(idleIrq), 0);
    check("R9 enable cleared", int'(irqEnable), 0);

    writeEn(1'b1);
    sendChar(9'h0F0, 1'b0, doneAt, idleC);
    highs(gapToIdle(1'b0));
    @(negedge clk);
    check("R5 irq for soft reset case", int'(idleIrq), 1);
    @(negedge clk);
    softRst = 1'b1;
    @(negedge clk);
    softRst = 1'b0;
    check("R9 soft reset drops irq", int'(idleIrq), 0);
    check("R9 soft reset clears enable", int'(irqEnable), 0);

    // enable set late while idle and armed
    sendChar(9'h012, 1'b0, doneAt, idleC);
    highs(gapToIdle(1'b0));
    @(negedge clk);
    check("R10 idle while disabled", int'(lineIdle), 1);
    check("R10 no irq while disabled", int'(idleIrq), 0);
    writeEn(1'b1);
    @(negedge clk);
    check("R10 irq after late enable", int'(idleIrq), 1);
    pulseAck();

    // long frames
    sendChar(9'h1FF, 1'b1, doneAt, idleC);
    check("R4 charDone tick long", doneAt, doneTick(1'b1));
    highs(gapToIdle(1'b1) - 1);
    check("R2 long gap below threshold", int'(lineIdle), 0);
    tick(1'b1);
    check("R2 long gap at threshold", int'(lineIdle), 1);
    @(negedge clk);
    check("R5 irq long frame", int'(idleIrq), 1);
    pulseAck();

    // random passes from a fresh reset
    doReset();
    longWord = 1'b0;
    check("R1 lineIdle after second reset", int'(lineIdle), 0);
    check("R1 enable after second reset", int'(irqEnable), 0);
    writeEn(1'b1);
    armedM = 1'b0;
    for (int it = 0; it < 40; it++) begin
      lw = 1'($urandom_range(1, 0));
      d = 9'($urandom);
      sendChar(d, lw, doneAt, idleC);
      check("R4 random charDone tick", doneAt, doneTick(lw));
      check("R3 random confirm clears idle", idleC, 0);
      armedM = 1'b1;
      g = $urandom_range(gapToIdle(lw) + 12, 0);
      if (it % 5 == 0) g = gapToIdle(lw) - (it % 2);
      highs(g);
      @(negedge clk);
      if (g >= gapToIdle(lw)) begin
        check("R2 random idle", int'(lineIdle), 1);
        check("R5 random irq", int'(idleIrq), int'(armedM));
        if (armedM) begin
          armedM = 1'b0;
          pulseAck();
          check("R7 random no refire", int'(idleIrq), 0);
        end
      end else begin
        check("R2 random not idle", int'(lineIdle), 0);
        check("R5 random no irq", int'(idleIrq), 0);
      end
    end

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule